// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Minimum Deadtime

This block sits between a PWM source and the two gate drivers of one inverter leg. A full three-phase bridge uses three copies. Each copy takes two active-low commands, one for the upper switch and one for the lower switch. It returns two active-high gate enables. The block never lets both switches conduct at once. When both commands ask for conduction together, it turns both gates off and gives neither side priority.

When one gate turns off, the block holds the other gate off until a fixed number of clock cycles has passed with both gates off. If the commands already leave a gap at least that long, they pass through with only the block's single register stage of latency, and no extra delay is added.

A two-bit enable mask from the fault supervisor can force either gate off. A gate that the mask has forced off turns on again only after it has itself been off for the full deadtime. All gate outputs are registered. Turn-off always takes effect on the next clock edge.

Top module: `hb_deadtime_leg`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, both `gate_hi` and `gate_lo` are 0. Reset leaves both sides ready to turn on at once.
- R2: The commands are active low. `hi_cmd_n`=0 with `lo_cmd_n`=1 requests the upper gate, and the reverse requests the lower gate. A permitted turn-on appears at the output one clock after the edge that first samples the request.
- R3: When both commands are 0 at a clock edge, both gates are 0 after that edge. They stay 0 for as long as the overlap lasts.
- R4: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R5: After either gate falls, the opposite gate stays 0 for at least `DT_CYCLES` full cycles in which both gates are 0. If the opposite side is requested at once, that both-off interval is exactly `DT_CYCLES` cycles.
- R6: When the commanded gap between one command releasing and the other asserting is `g` cycles, the both-off interval is `g` cycles if `g >= DT_CYCLES`, with no added delay, and `DT_CYCLES` cycles otherwise.
- R7: Turn-off is never delayed. A gate is 0 one clock after its command is released, after an overlap begins, or after its mask bit clears.
- R8: `en_mask` bit 1 enables the upper gate and bit 0 enables the lower gate. A cleared bit forces that gate to 0 from the next edge on.
- R9: A gate forced off by its mask bit does not turn on again until it has been 0 for at least `DT_CYCLES` cycles, even if its mask bit returns sooner.
- R10: The same `DT_CYCLES` applies to the upper-to-lower and the lower-to-upper hand-over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd_n | input | 1 | Upper switch command, 0 requests conduction |
| lo_cmd_n | input | 1 | Lower switch command, 0 requests conduction |
| en_mask | input | 2 | Per-gate enable from the fault supervisor: bit 1 upper, bit 0 lower |
| gate_hi | output | 1 | Registered upper gate enable, active high |
| gate_lo | output | 1 | Registered lower gate enable, active high |

## Verification
The hardest case to reach from the ports is a mask-forced turn-off that overlaps with deadtime timing. Here the gate is limited by its own off-time rather than the opposite side's. The mask has to be released well before `DT_CYCLES` has passed, while the command keeps asking for conduction and the opposite gate has been idle for a long time.

The bench builds exactly that sequence. It then measures the length of the off interval. It also sweeps commanded gaps of zero, `DT_CYCLES-1`, `DT_CYCLES` and `DT_CYCLES+1` in both directions, so that the boundary between padded and pass-through gaps is hit exactly. A long random phase follows, with occasional mask drops. A behavioural timestamp model is compared against the outputs on every cycle.

// File: rtl/hb_leg_pkg.sv
// Shared definitions for the half-bridge interlock.
// Assumes bit 1 of any two-bit side vector is the upper switch, bit 0 the lower.
package hb_leg_pkg;

    localparam int SIDE_LO = 0;
    localparam int SIDE_HI = 1;
    localparam int NUM_SIDES = 2;

    // Decoded conduction request pair, upper side in the high bit
    typedef struct packed {
        logic hi;
        logic lo;
    } hb_pair_t;

endpackage

// File: rtl/hb_cmd_decode.sv
// Turns the two active-low commands into active-high requests.
// An overlap, where both commands ask for conduction, yields no request on either side.
// Assumes the commands are already synchronous to clk.
module hb_cmd_decode
    import hb_leg_pkg::*;
(
    input  logic     hi_cmd_n,
    input  logic     lo_cmd_n,
    output hb_pair_t req
);

    logic overlap;

    // Purpose: detect the forbidden simultaneous on-request
    always_comb begin
        overlap = ~hi_cmd_n & ~lo_cmd_n;
    end

    // Purpose: invert each command and blank both during overlap
    always_comb begin
        req.hi = ~hi_cmd_n & ~overlap;
        req.lo = ~lo_cmd_n & ~overlap;
    end

endmodule

// File: rtl/hb_side_gate.sv
// One gate of the leg: off-time counter, mask memory and the registered gate.
// Turn-on needs four things: the request, the enable, an opposite side that is
// off and has been off long enough, and (after a mask trip) enough off-time of
// its own. Turn-off follows the request or the enable on the next edge.
// Assumes DT_CYCLES >= 1 and that the two requests are never both high.
module hb_side_gate #(
    parameter int unsigned DT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic en,
    input  logic opp_gate,
    input  logic opp_ready,
    output logic gate,
    output logic ready
);

    localparam int CW = (DT_CYCLES > 1) ? $clog2(DT_CYCLES) : 1;
    localparam logic [CW-1:0] LIMIT_V = CW'(DT_CYCLES - 1);

    logic [CW-1:0] off_cnt;
    logic          masked;
    logic          start;
    logic          hold;

    // Purpose: own gate has been low long enough to hand over or recover
    always_comb begin
        ready = (off_cnt == LIMIT_V);
    end

    // Purpose: decide between keeping, starting and dropping the gate
    always_comb begin
        hold  = gate & req & en;
        start = ~gate & req & en & ~opp_gate & opp_ready & (~masked | ready);
    end

    // Purpose: count cycles since the gate went low, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cnt <= LIMIT_V;
        end else if (gate) begin
            off_cnt <= '0;
        end else if (off_cnt != LIMIT_V) begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    // Purpose: remember a mask trip until the gate is turned on again
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked <= 1'b0;
        end else if (!en) begin
            masked <= 1'b1;
        end else if (start) begin
            masked <= 1'b0;
        end
    end

    // Purpose: registered gate enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
        end else begin
            gate <= hold | start;
        end
    end

endmodule

// File: rtl/hb_deadtime_leg.sv
// Top of one inverter leg interlock: decodes the commands and runs two
// cross-coupled side gates, each watching the other's gate and off-time.
// Assumes synchronous inputs and DT_CYCLES >= 1.
module hb_deadtime_leg
    import hb_leg_pkg::*;
#(
    parameter int unsigned DT_CYCLES = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_cmd_n,
    input  logic       lo_cmd_n,
    input  logic [1:0] en_mask,
    output logic       gate_hi,
    output logic       gate_lo
);

    hb_pair_t              req;
    logic [NUM_SIDES-1:0]  req_v;
    logic [NUM_SIDES-1:0]  gate_v;
    logic [NUM_SIDES-1:0]  ready_v;

    hb_cmd_decode u_dec (
        .hi_cmd_n (hi_cmd_n),
        .lo_cmd_n (lo_cmd_n),
        .req      (req)
    );

    // Purpose: flatten the request pair into a side-indexed vector
    always_comb begin
        req_v = req;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        hb_side_gate #(
            .DT_CYCLES (DT_CYCLES)
        ) u_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_v[s]),
            .en        (en_mask[s]),
            .opp_gate  (gate_v[NUM_SIDES-1-s]),
            .opp_ready (ready_v[NUM_SIDES-1-s]),
            .gate      (gate_v[s]),
            .ready     (ready_v[s])
        );
    end

    // Purpose: drive the named outputs from the side vector
    always_comb begin
        gate_hi = gate_v[SIDE_HI];
        gate_lo = gate_v[SIDE_LO];
    end

endmodule

// File: rtl/hb_deadtime_leg_chk.sv
// Property checker for hb_deadtime_leg. It is bound to every instance.
// It keeps its own off-time counters, independent of the design's counters.
module hb_deadtime_leg_chk #(
    parameter int unsigned DT_CYCLES = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hi_cmd_n,
    input logic       lo_cmd_n,
    input logic [1:0] en_mask,
    input logic       gate_hi,
    input logic       gate_lo
);

    int hi_off;
    int lo_off;

    // Purpose: cycles each gate has been low, saturating at the deadtime
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_off <= int'(DT_CYCLES);
            lo_off <= int'(DT_CYCLES);
        end else begin
            hi_off <= gate_hi ? 0 : ((hi_off < int'(DT_CYCLES)) ? hi_off + 1 : hi_off);
            lo_off <= gate_lo ? 0 : ((lo_off < int'(DT_CYCLES)) ? lo_off + 1 : lo_off);
        end
    end

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    a_r3_overlap_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_cmd_n && !lo_cmd_n) |=> (!gate_hi && !gate_lo));

    a_r7_hi_release: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cmd_n |=> !gate_hi);

    a_r7_lo_release: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cmd_n |=> !gate_lo);

    a_r8_mask_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mask[1] |=> !gate_hi);

    a_r8_mask_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mask[0] |=> !gate_lo);

    a_r5_dead_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> (lo_off >= int'(DT_CYCLES)));

    a_r10_dead_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> (hi_off >= int'(DT_CYCLES)));

endmodule

bind hb_deadtime_leg hb_deadtime_leg_chk #(
    .DT_CYCLES (DT_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_cmd_n (hi_cmd_n),
    .lo_cmd_n (lo_cmd_n),
    .en_mask  (en_mask),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
);

// File: tb/sim_hb_deadtime_leg.sv
module sim_hb_deadtime_leg;

    localparam int DT  = 12;
    localparam int BIG = 1 << 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hin = 1'b1;
    logic       lin = 1'b1;
    logic [1:0] msk = 2'b11;
    logic       gate_hi;
    logic       gate_lo;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    hb_deadtime_leg #(.DT_CYCLES(DT)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cmd_n (hin),
        .lo_cmd_n (lin),
        .en_mask  (msk),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    // Behavioural reference: timestamps of off-time per gate
    bit m_h, m_l, k_h, k_l;
    int low_h, low_l;
    always @(posedge clk) begin
        bit rh, rl, nh, nl;
        if (!rst_n) begin
            m_h = 0; m_l = 0; k_h = 0; k_l = 0; low_h = BIG; low_l = BIG;
        end else begin
            rh = (hin == 1'b0) && (lin == 1'b1);
            rl = (lin == 1'b0) && (hin == 1'b1);
            nh = rh && msk[1] && (m_h || (!m_l && low_l >= DT && (!k_h || low_h >= DT)));
            nl = rl && msk[0] && (m_l || (!m_h && low_h >= DT && (!k_l || low_l >= DT)));
            if (!msk[1]) k_h = 1; else if (!m_h && nh) k_h = 0;
            if (!msk[0]) k_l = 1; else if (!m_l && nl) k_l = 0;
            low_h = nh ? 0 : ((low_h < BIG) ? low_h + 1 : low_h);
            low_l = nl ? 0 : ((low_l < BIG) ? low_l + 1 : low_l);
            m_h = nh; m_l = nl;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(gate_hi == m_h, {tag, " gate_hi"}, gate_hi, m_h);
            chk(gate_lo == m_l, {tag, " gate_lo"}, gate_lo, m_l);
            chk(!(gate_hi && gate_lo), "R4 exclusive", gate_hi & gate_lo, 0);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic drive(input bit h, input bit l, input logic [1:0] m, input int n);
        hin = h; lin = l; msk = m;
        repeat (n) @(negedge clk);
    endtask

    // Hand over from one side to the other with a commanded gap of g cycles;
    // returns the number of both-off cycles seen.
    task automatic handover(input bit to_lo, input int g, output int cnt);
        if (to_lo) drive(0, 1, 2'b11, 2 * DT); else drive(1, 0, 2'b11, 2 * DT);
        cnt = 0;
        hin = 1; lin = 1;
        if (g == 0) begin
            if (to_lo) lin = 0; else hin = 0;
        end
        for (int i = 1; i < 8 * DT; i++) begin
            @(negedge clk);
            if (to_lo ? gate_lo : gate_hi) break;
            if (!gate_hi && !gate_lo) cnt++;
            if (i == g) begin
                if (to_lo) lin = 0; else hin = 0;
            end
        end
    endtask

    initial begin
        repeat (BIG / 8) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int cnt;
        int gaps[4];
        gaps[0] = 0; gaps[1] = DT - 1; gaps[2] = DT; gaps[3] = DT + 1;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R1 in reset", {gate_hi, gate_lo}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R1 after release", {gate_hi, gate_lo}, 0);

        // R2: lower request, one cycle latency from reset-ready state
        tag = "R2";
        drive(1, 0, 2'b11, 1);
        chk(gate_lo == 1'b1, "R2 lo on", gate_lo, 1);
        drive(1, 0, 2'b11, 20);

        // R7: release is immediate
        tag = "R7";
        drive(1, 1, 2'b11, 1);
        chk(gate_lo == 1'b0, "R7 lo release", gate_lo, 0);

        // R6: long idle gap, upper turns on with just the register latency
        tag = "R6";
        drive(1, 1, 2'b11, DT + 5);
        drive(0, 1, 2'b11, 1);
        chk(gate_hi == 1'b1, "R6 hi after long gap", gate_hi, 1);
        drive(0, 1, 2'b11, 10);

        // R5/R6/R10: gap sweep in both directions
        foreach (gaps[j]) begin
            tag = "R5";
            handover(1, gaps[j], cnt);
            chk(cnt == ((gaps[j] > DT) ? gaps[j] : DT), "R5 R6 hi->lo gap", cnt,
                (gaps[j] > DT) ? gaps[j] : DT);
            tag = "R10";
            handover(0, gaps[j], cnt);
            chk(cnt == ((gaps[j] > DT) ? gaps[j] : DT), "R10 R6 lo->hi gap", cnt,
                (gaps[j] > DT) ? gaps[j] : DT);
        end

        // R3: overlap drops both and holds them off
        tag = "R3";
        drive(0, 1, 2'b11, 2 * DT);
        drive(0, 0, 2'b11, 1);
        chk(!gate_hi && !gate_lo, "R3 overlap start", {gate_hi, gate_lo}, 0);
        drive(0, 0, 2'b11, 20);
        chk(!gate_hi && !gate_lo, "R3 overlap held", {gate_hi, gate_lo}, 0);
        drive(0, 1, 2'b11, 2 * DT);

        // R8/R9: upper mask trip, short release, own off-time governs
        tag = "R8";
        drive(0, 1, 2'b01, 1);
        chk(gate_hi == 1'b0, "R8 hi masked", gate_hi, 0);
        drive(0, 1, 2'b01, 2);
        tag = "R9";
        msk = 2'b11;
        cnt = 3;
        for (int i = 0; i < 8 * DT; i++) begin
            @(negedge clk);
            if (gate_hi) break;
            cnt++;
        end
        chk(cnt == DT, "R9 hi off-time after mask", cnt, DT);

        // R8: lower mask bit
        tag = "R8";
        drive(1, 0, 2'b11, 3 * DT);
        drive(1, 0, 2'b10, 1);
        chk(gate_lo == 1'b0, "R8 lo masked", gate_lo, 0);
        chk(gate_hi == 1'b0, "R8 hi unaffected", gate_hi, 0);
        drive(1, 0, 2'b11, 3 * DT);

        // R4: random stress with occasional mask drops
        tag = "R4";
        for (int i = 0; i < 300; i++) begin
            drive(1'($urandom), 1'($urandom),
                  (($urandom % 8) == 0) ? 2'($urandom) : 2'b11,
                  1 + int'($urandom % (2 * DT)));
        end

        finish_run();
    end

endmodule